// File: doc/BRIEF.md
# Parallel NOR Flash Erase/Program Sequencer

This block sits on the host side of a 16-bit parallel NOR flash. A client asks for one of two operations: erase the block that holds a given word address, or program a single data word at a given word address. It presents the operation, the target word address and the data word, and pulses a start strobe. The sequencer then issues every write cycle the device needs. Each operation opens with fixed unlock cycles at fixed magic addresses and closes with a cycle aimed at the target.

After the last write, the sequencer watches the device's ready line. Erase and program each have their own timeout, given as a number of clocks. The outcome reaches the client as a one-clock done pulse and an error flag that is valid with it.

Bus AC timing is reduced to two numbers: the clocks for which a write strobe is held low and the clocks of idle bus after each strobe. The ready input can pass through an optional synchronizer and can be set active high or active low.

Top module: `nor_cmd_seq`

## Requirements
- R1: An erase request produces exactly six bus writes, given as (address, data) with values in hex: (555, AA), (2AA, 55), (555, 80), (555, AA), (2AA, 55), then (client address, 30). The block is chosen by the address of that final write.
- R2: A program request produces exactly four bus writes: (555, AA), (2AA, 55), (555, A0), then (client address, client data word). A second word needs a new request.
- R3: During every write, both `flash_ce_n` and `flash_we_n` are low for exactly STROBE_CLKS consecutive clocks, and address and data stay stable. After every write, both lines are high for at least GAP_CLKS clocks.
- R4: Polling starts once the idle gap after the final write has ended. The ready input is sampled once per clock. With SYNC_STAGES=0, a ready level seen at a clock edge makes `done` high for exactly one clock right after that edge, with `err` low.
- R5: Suppose ready is not seen within the timeout of the current operation: ERASE_TMO_CLKS polling clocks for an erase, PROG_TMO_CLKS for a program. Then `done` pulses for one clock with `err` high at the clock right after the last polling clock. `err` is never high without `done`.
- R6: `busy` is high from the clock of the first write until the sequence finishes. It is low in the clock where `done` is high and while idle. No write occurs while `busy` is low.
- R7: A start pulse that arrives while `busy` is high is ignored. The write sequence in progress and its target stay unchanged, and no second `done` follows.
- R8: While reset is held, `flash_ce_n` and `flash_we_n` are high and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| op_erase | input | 1 | Operation select: 1 = block erase, 0 = word program |
| addr | input | ADDR_W | Target word address |
| wdata | input | DATA_W | Data word for program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| flash_addr | output | ADDR_W | Flash word address |
| flash_dq | output | DATA_W | Flash write data |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_rdy | input | 1 | Device ready / not busy |

## Verification
The bench builds the sequencer with STROBE_CLKS=3, GAP_CLKS=2, PROG_TMO_CLKS=6, ERASE_TMO_CLKS=11, no synchronizer and an active-high ready line. Timeouts this short let the bench sweep every clock at which ready can return for both operations. That sweep covers a return inside the idle gap, on the first polling clock, on the very last polling clock, one clock too late, and never. For each case the bench checks the exact done latency and error value it works out arithmetically. A strobe longer than one clock and a gap longer than one clock make errors in pulse width, hold time and spacing visible. Start pulses injected during a sequence exercise the ignore rule.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

   typedef enum logic { OP_PROGRAM = 1'b0, OP_ERASE = 1'b1 } nor_op_e;

   typedef enum logic [1:0] { ST_IDLE, ST_WRITE, ST_POLL } seq_state_e;

   typedef enum logic [1:0] { SRC_FIXED, SRC_TARGET_CMD, SRC_TARGET_DATA } step_src_e;

   localparam int PROG_LEN  = 4;
   localparam int ERASE_LEN = 6;
   localparam int IDX_W     = $clog2(ERASE_LEN);

   localparam logic [10:0] MAGIC_HI = 11'h555;
   localparam logic [10:0] MAGIC_LO = 11'h2AA;
   localparam logic [7:0]  KEY_FIRST     = 8'hAA;
   localparam logic [7:0]  KEY_SECOND    = 8'h55;
   localparam logic [7:0]  CODE_PROGRAM  = 8'hA0;
   localparam logic [7:0]  CODE_ERASE_ARM = 8'h80;
   localparam logic [7:0]  CODE_ERASE_GO  = 8'h30;

   typedef struct packed {
      step_src_e   src;
      logic [10:0] magic_addr;
      logic [7:0]  code;
   } step_t;

   function automatic step_t step_of(nor_op_e op, logic [IDX_W-1:0] idx);
      step_t s;
      s.src        = SRC_FIXED;
      s.magic_addr = MAGIC_HI;
      s.code       = KEY_FIRST;
      case (idx)
         3'd0: ;
         3'd1: begin
            s.magic_addr = MAGIC_LO;
            s.code       = KEY_SECOND;
         end
         3'd2: s.code = (op == OP_ERASE) ? CODE_ERASE_ARM : CODE_PROGRAM;
         3'd3: begin
            if (op != OP_ERASE) begin
               s.src  = SRC_TARGET_DATA;
               s.code = 8'h00;
            end
         end
         3'd4: begin
            s.magic_addr = MAGIC_LO;
            s.code       = KEY_SECOND;
         end
         default: begin
            s.src  = SRC_TARGET_CMD;
            s.code = CODE_ERASE_GO;
         end
      endcase
      return s;
   endfunction

endpackage

// File: rtl/nor_seq_steps.sv
module nor_seq_steps
   import nor_seq_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 16
) (
   input  nor_op_e                 op,
   input  logic [IDX_W-1:0]        idx,
   input  logic [ADDR_W-1:0]       tgt_addr,
   input  logic [DATA_W-1:0]       tgt_data,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [DATA_W-1:0]       bus_data,
   output logic                    is_last
);

   localparam logic [IDX_W-1:0] LAST_PROG  = IDX_W'(PROG_LEN - 1);
   localparam logic [IDX_W-1:0] LAST_ERASE = IDX_W'(ERASE_LEN - 1);

   generate
      if (ADDR_W < 11) begin : g_bad_addr
         $error("ADDR_W must hold the 11-bit unlock addresses");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold the 8-bit command codes");
      end
   endgenerate

   step_t st;

   always_comb begin
      st = step_of(op, idx);
      case (st.src)
         SRC_FIXED: begin
            bus_addr = ADDR_W'(st.magic_addr);
            bus_data = DATA_W'(st.code);
         end
         SRC_TARGET_CMD: begin
            bus_addr = tgt_addr;
            bus_data = DATA_W'(st.code);
         end
         default: begin
            bus_addr = tgt_addr;
            bus_data = tgt_data;
         end
      endcase
      is_last = (idx == ((op == OP_ERASE) ? LAST_ERASE : LAST_PROG));
   end

endmodule

// File: rtl/nor_seq_strobe.sv
module nor_seq_strobe #(
   parameter int STROBE_CLKS = 4,
   parameter int GAP_CLKS    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic strobe,
   output logic slot_end
);

   localparam int SLOT   = STROBE_CLKS + GAP_CLKS;
   localparam int SLOT_W = $clog2(SLOT + 1);

   generate
      if (STROBE_CLKS < 1) begin : g_bad_strobe
         $error("STROBE_CLKS must be at least 1");
      end
      if (GAP_CLKS < 1) begin : g_bad_gap
         $error("GAP_CLKS must be at least 1");
      end
   endgenerate

   logic [SLOT_W-1:0] slot_cnt;

   assign strobe   = run && (slot_cnt < SLOT_W'(STROBE_CLKS));
   assign slot_end = run && (slot_cnt == SLOT_W'(SLOT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot_cnt <= '0;
      else if (!run || slot_end)
         slot_cnt <= '0;
      else
         slot_cnt <= slot_cnt + 1'b1;
   end

   // R3: the slot counter never runs past one strobe plus its gap
   p_slot_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slot_cnt < SLOT_W'(SLOT));

endmodule

// File: rtl/nor_seq_poll.sv
module nor_seq_poll #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit READY_HIGH  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rdy_pin,
   input  logic             arm,
   input  logic [CNT_W-1:0] limit,
   output logic             hit,
   output logic             expire
);

   logic ready_lvl;
   logic ready_s;
   logic [CNT_W-1:0] wait_cnt;

   assign ready_lvl = READY_HIGH ? rdy_pin : ~rdy_pin;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign ready_s = ready_lvl;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q <= '0;
            else
               sync_q <= SYNC_STAGES'({sync_q, ready_lvl});
         end
         assign ready_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign hit    = arm && ready_s;
   assign expire = arm && !ready_s && (wait_cnt == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_cnt <= '0;
      else if (!arm || hit || expire)
         wait_cnt <= '0;
      else
         wait_cnt <= wait_cnt + 1'b1;
   end

   // R5: the wait counter stays below the selected timeout while polling
   p_wait_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> (wait_cnt < limit));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int ADDR_W         = 18,
   parameter int DATA_W         = 16,
   parameter int STROBE_CLKS    = 4,
   parameter int GAP_CLKS       = 1,
   parameter int PROG_TMO_CLKS  = 20000,
   parameter int ERASE_TMO_CLKS = 600000000,
   parameter int SYNC_STAGES    = 2,
   parameter bit READY_HIGH     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_erase,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [ADDR_W-1:0] flash_addr,
   output logic [DATA_W-1:0] flash_dq,
   output logic              flash_ce_n,
   output logic              flash_we_n,
   input  logic              flash_rdy
);

   localparam int MAX_TMO = (PROG_TMO_CLKS > ERASE_TMO_CLKS) ? PROG_TMO_CLKS : ERASE_TMO_CLKS;
   localparam int CNT_W   = $clog2(MAX_TMO + 1);

   generate
      if (PROG_TMO_CLKS < 1 || ERASE_TMO_CLKS < 1) begin : g_bad_tmo
         $error("timeouts must be at least one clock");
      end
   endgenerate

   seq_state_e        state;
   nor_op_e           op_q;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              done_q;
   logic              err_q;
   logic              strobe;
   logic              slot_end;
   logic              is_last;
   logic              hit;
   logic              expire;
   logic [CNT_W-1:0]  limit;

   nor_seq_steps #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_steps (
      .op       (op_q),
      .idx      (idx),
      .tgt_addr (addr_q),
      .tgt_data (data_q),
      .bus_addr (flash_addr),
      .bus_data (flash_dq),
      .is_last  (is_last)
   );

   nor_seq_strobe #(
      .STROBE_CLKS (STROBE_CLKS),
      .GAP_CLKS    (GAP_CLKS)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state == ST_WRITE),
      .strobe   (strobe),
      .slot_end (slot_end)
   );

   assign limit = (op_q == OP_ERASE) ? CNT_W'(ERASE_TMO_CLKS) : CNT_W'(PROG_TMO_CLKS);

   nor_seq_poll #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES),
      .READY_HIGH  (READY_HIGH)
   ) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy_pin (flash_rdy),
      .arm     (state == ST_POLL),
      .limit   (limit),
      .hit     (hit),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         op_q   <= OP_PROGRAM;
         idx    <= '0;
         addr_q <= '0;
         data_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_WRITE;
                  op_q   <= nor_op_e'(op_erase);
                  idx    <= '0;
                  addr_q <= addr;
                  data_q <= wdata;
               end
            end
            ST_WRITE: begin
               if (slot_end) begin
                  if (is_last)
                     state <= ST_POLL;
                  else
                     idx <= idx + 1'b1;
               end
            end
            ST_POLL: begin
               if (hit) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else if (expire) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state != ST_IDLE);
   assign done       = done_q;
   assign err        = err_q;
   assign flash_ce_n = ~strobe;
   assign flash_we_n = ~strobe;

   // R3: address and data hold while the write strobe stays low
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq)));

   // R4: completion is a single-clock pulse
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: the timeout flag only accompanies done
   p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R6: no bus write outside an operation, and busy is low at done
   p_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !flash_we_n |-> busy);
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7: a request during an operation leaves the latched target alone
   p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (op_q == $past(op_q) && addr_q == $past(addr_q) && data_q == $past(data_q)));

endmodule

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;

   localparam int AW = 18;
   localparam int DW = 16;
   localparam int S  = 3;
   localparam int G  = 2;
   localparam int PT = 6;
   localparam int ET = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_erase = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          busy, done, err;
   logic [AW-1:0] flash_addr;
   logic [DW-1:0] flash_dq;
   logic          flash_ce_n, flash_we_n;
   logic          rdy = 1'b1;

   always #2 clk = ~clk;

   nor_cmd_seq #(
      .ADDR_W(AW), .DATA_W(DW), .STROBE_CLKS(S), .GAP_CLKS(G),
      .PROG_TMO_CLKS(PT), .ERASE_TMO_CLKS(ET), .SYNC_STAGES(0), .READY_HIGH(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
      .addr(addr), .wdata(wdata), .busy(busy), .done(done), .err(err),
      .flash_addr(flash_addr), .flash_dq(flash_dq),
      .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_rdy(rdy)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   // bus monitor state
   logic [AW-1:0] wa [0:15];
   logic [DW-1:0] wd [0:15];
   logic [AW-1:0] cur_a;
   logic [DW-1:0] cur_d;
   int  nwr = 0, lo_cnt = 0, hi_run = 0, exp_n = 0;
   int  bad_len = 0, bad_stab = 0, bad_gap = 0, busy_bad = 0;
   bit  in_wr = 0, waiting = 0, last_err = 0;
   int  pk = 0, rdy_delay = -1, done_cnt = 0, done_pk = -1;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (!flash_we_n) begin
            if (flash_ce_n) bad_len++;
            if (!busy) busy_bad++;
            if (!in_wr) begin
               in_wr = 1; lo_cnt = 1; cur_a = flash_addr; cur_d = flash_dq;
               if (nwr > 0 && hi_run < G) bad_gap++;
            end else begin
               lo_cnt++;
               if (flash_addr !== cur_a || flash_dq !== cur_d) bad_stab++;
            end
            hi_run = 0;
         end else begin
            if (!flash_ce_n) bad_len++;
            hi_run++;
            if (in_wr) begin
               in_wr = 0;
               if (lo_cnt != S) bad_len++;
               if (nwr < 16) begin wa[nwr] = cur_a; wd[nwr] = cur_d; end
               nwr++;
               if (nwr == exp_n) begin waiting = 1; pk = 0; rdy = 1'b0; end
            end else if (waiting) begin
               pk++;
               if (pk == rdy_delay) rdy = 1'b1;
            end
         end
         if (done) begin
            done_cnt++;
            last_err = err;
            if (waiting) done_pk = pk;
            waiting = 0;
            if (busy) busy_bad++;
            rdy = 1'b1;
         end
      end
   end

   function automatic logic [AW-1:0] exp_addr(bit er, int i, logic [AW-1:0] t);
      if (er) begin
         case (i)
            0, 2, 3: return AW'(18'h555);
            1, 4:    return AW'(18'h2AA);
            default: return t;
         endcase
      end else begin
         case (i)
            0, 2:    return AW'(18'h555);
            1:       return AW'(18'h2AA);
            default: return t;
         endcase
      end
   endfunction

   function automatic logic [DW-1:0] exp_data(bit er, int i, logic [DW-1:0] d);
      if (er) begin
         case (i)
            0, 3:    return 16'h00AA;
            1, 4:    return 16'h0055;
            2:       return 16'h0080;
            default: return 16'h0030;
         endcase
      end else begin
         case (i)
            0:       return 16'h00AA;
            1:       return 16'h0055;
            2:       return 16'h00A0;
            default: return d;
         endcase
      end
   endfunction

   task automatic run_op(input bit er, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int dly, input bit inject);
      int base;
      int guard;
      int mism;
      int tmo_lim;
      bit tmo;
      int exp_pk;
      string rq;
      nwr = 0; exp_n = er ? 6 : 4; rdy_delay = dly; done_pk = -1;
      bad_len = 0; bad_stab = 0; bad_gap = 0; busy_bad = 0;
      base = done_cnt;
      @(negedge clk);
      start = 1'b1; op_erase = er; addr = a; wdata = d;
      @(negedge clk);
      start = 1'b0;
      if (inject) begin
         repeat (5) @(negedge clk);
         start = 1'b1; op_erase = ~er; addr = ~a; wdata = ~d;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (done_cnt == base && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (6) @(negedge clk);
      rq = er ? "R1" : "R2";
      chk(nwr == exp_n, rq, "write count", nwr, exp_n);
      mism = 0;
      for (int i = 0; i < exp_n && i < nwr; i++)
         if (wa[i] !== exp_addr(er, i, a) || wd[i] !== exp_data(er, i, d)) mism++;
      chk(mism == 0, rq, "sequence mismatches", mism, 0);
      chk(bad_len + bad_stab + bad_gap == 0, "R3", "strobe shape faults", bad_len + bad_stab + bad_gap, 0);
      chk(busy_bad == 0, "R6", "busy faults", busy_bad, 0);
      chk(done_cnt == base + 1, inject ? "R7" : "R4", "done pulses", done_cnt - base, 1);
      tmo_lim = er ? ET : PT;
      tmo = (dly < 0) || (dly > G + tmo_lim - 1);
      exp_pk = tmo ? (G + tmo_lim) : (((dly > G) ? dly : G) + 1);
      chk(last_err == tmo, tmo ? "R5" : "R4", "err flag", int'(last_err), int'(tmo));
      chk(done_pk == exp_pk, tmo ? "R5" : "R4", "done latency", done_pk, exp_pk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(flash_ce_n && flash_we_n, "R8", "strobes high in reset", int'({flash_ce_n, flash_we_n}), 3);
      chk(!busy && !done && !err, "R8", "status low in reset", int'({busy, done, err}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // timing sweep for both operations over every ready return point
      for (int er = 0; er < 2; er++) begin
         for (int dl = 1; dl <= G + (er ? ET : PT) + 1; dl++)
            run_op(er[0], AW'(18'h2A5C3 ^ (dl * 18'h1111)), DW'(16'h1234 + dl * 16'h0F0F), dl, 1'b0);
         run_op(er[0], AW'(18'h15A3C), 16'h5AA5, -1, 1'b0);
      end

      // boundary targets and data words
      run_op(1'b1, 18'h3FFFF, 16'h0000, 4, 1'b0);
      run_op(1'b1, 18'h00000, 16'hFFFF, 4, 1'b0);
      run_op(1'b0, 18'h3FFFF, 16'hFFFF, 3, 1'b0);
      run_op(1'b0, 18'h00000, 16'h0000, 3, 1'b0);

      // R7: requests during an operation are dropped
      run_op(1'b0, 18'h0BEEF, 16'hC0DE, 2, 1'b1);
      run_op(1'b1, 18'h21000, 16'h0001, 5, 1'b1);
      run_op(1'b1, 18'h30F0F, 16'h0002, -1, 1'b1);

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule